// File: doc/BRIEF.md
# Link Packet Parser with Ping Responder

This block terminates the receive side of a word-oriented link between boards. Packets arrive as a stream of 32-bit words with a valid/ready handshake. The parser reads a header word and an event-identifier word, walks the payload, and compares the closing CRC word with a CRC it builds over all earlier words of the packet. User-data payloads are passed straight through to a payload output stream, with no buffering, and carry an end marker on their final word.

Command packets that test the link are answered inside the block. A valid test request produces a three-word reply packet on a separate output stream, and the parser accepts no further input until that reply has gone out. A valid test reply from the far end raises a one-cycle "link check complete" pulse. Packets flagged as errors have their 12-bit error code latched and counted. Any inconsistent packet, such as one with a bad CRC, a reserved type, a misplaced test flag or an unknown flag value, sets a sticky protocol-error bit and causes no other action.

Top module: `lpp_link_parser`

## Requirements
- R1: After reset, in_ready is 1, pl_valid, rp_valid and ping_ok are 0, proto_err is 0, err_cnt is 0 and err_code is 0.
- R2: Word 0 of a packet is the header: type in bits 31:30, flags in bits 29:16 and payload word count in bits 15:0. Word 1 is the event ID, then the payload, then one CRC word. For type 01 (data) with flags 0, each payload word appears on pl_data in arrival order, and pl_last is 1 only on the final payload word.
- R3: The CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. Each word is shifted in MSB first, with no reflection and no final inversion, over every word before the CRC word. On a mismatch, no reply, pulse or error count results and proto_err is set. proto_err stays set until reset. Data payload is already forwarded by then.
- R4: A packet of type 00 (command) with flags 0x0001 and a good CRC produces the reply words 0x00020000, the received event ID, and the CRC of those two words, with rp_last on the third word. Its payload is not forwarded.
- R5: From the reply's first word until its last word is accepted, in_ready is 0, and a stalled reply word holds its value.
- R6: A command packet with flags 0x0002 and a good CRC gives one ping_ok pulse that lasts exactly one cycle.
- R7: Flags with bits 13:12 equal to 01 mark an error packet of either type. With a good CRC, flags bits 11:0 are latched to err_code and err_cnt is incremented. Its payload is not forwarded.
- R8: Flags 0x0001 or 0x0002 with the data type are dropped and set proto_err.
- R9: Types 10 and 11 are reserved. Such packets are dropped whatever their flags, their payload is not forwarded, and proto_err is set.
- R10: A packet with a payload count of 0 consists of header, event ID and CRC only, and is handled completely.
- R11: With SAT_CNT=1, err_cnt stops at its all-ones value.
- R12: While a forwarded payload word waits with pl_ready at 0, in_ready is 0.
- R13: A command packet with flags 0 is consumed with no effect. Any other flag value not listed above is dropped and sets proto_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| pl_valid | output | 1 | Payload word valid |
| pl_ready | input | 1 | Payload sink ready |
| pl_data | output | 32 | Payload word |
| pl_last | output | 1 | Final payload word of the packet |
| rp_valid | output | 1 | Reply word valid |
| rp_ready | input | 1 | Reply sink ready |
| rp_data | output | 32 | Reply word |
| rp_last | output | 1 | Final reply word (CRC) |
| ping_ok | output | 1 | One-cycle pulse: test reply received |
| proto_err | output | 1 | Sticky protocol error |
| err_code | output | 12 | Code of the last error packet |
| err_cnt | output | CNT_W | Error packet count |

## Verification
On every cycle, the assertions check the handshake rules: input is blocked while a reply is pending and while a payload word is stalled, and a stalled reply word keeps its value. They also check that ping_ok is a single-cycle pulse, that proto_err never clears, and that err_cnt only ever steps by one and holds once saturated. Which packets are forwarded, answered, counted or rejected depends on type, flag and CRC combinations. The bench's scenarios show this, along with the exact payload order, the reply words with their CRC, and the latched error code.

// File: rtl/lpp_pkg.sv
package lpp_pkg;
   localparam int          WORD_W    = 32;
   localparam int          CODE_W    = 12;
   localparam int          LEN_W     = 16;
   localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
   localparam logic [13:0] FL_NORMAL = 14'h0000;
   localparam logic [13:0] FL_PING   = 14'h0001;
   localparam logic [13:0] FL_PONG   = 14'h0002;
   localparam logic [1:0]  TY_CMD    = 2'b00;
   localparam logic [1:0]  TY_DATA   = 2'b01;
   localparam logic [31:0] REPLY_HDR = {TY_CMD, FL_PONG, 16'h0000};

   typedef enum logic [2:0] {K_FWD, K_NOP, K_PING, K_PONG, K_ERR, K_BAD} pkt_kind_e;
   typedef enum logic [2:0] {S_HDR, S_EVT, S_PAY, S_CRC, S_RPL} rx_state_e;

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ CRC_POLY;
      end
      return r;
   endfunction
endpackage

// File: rtl/lpp_hdr_decode.sv
module lpp_hdr_decode
   import lpp_pkg::*;
(
   input  logic [WORD_W-1:0] hdr,
   output pkt_kind_e         kind,
   output logic [CODE_W-1:0] code,
   output logic [LEN_W-1:0]  len
);
   logic [1:0]  ty;
   logic [13:0] fl;

   assign ty   = hdr[31:30];
   assign fl   = hdr[29:16];
   assign len  = hdr[LEN_W-1:0];
   assign code = fl[CODE_W-1:0];

   always_comb begin
      if (ty != TY_CMD && ty != TY_DATA)  kind = K_BAD;
      else if (fl == FL_NORMAL)           kind = (ty == TY_DATA) ? K_FWD : K_NOP;
      else if (fl == FL_PING)             kind = (ty == TY_CMD) ? K_PING : K_BAD;
      else if (fl == FL_PONG)             kind = (ty == TY_CMD) ? K_PONG : K_BAD;
      else if (fl[13:12] == 2'b01)        kind = K_ERR;
      else                                kind = K_BAD;
   end
endmodule

// File: rtl/lpp_crc_acc.sv
module lpp_crc_acc
   import lpp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              restart,
   input  logic [WORD_W-1:0] word,
   output logic [31:0]       crc
);
   always_ff @(posedge clk) begin
      if (rst)     crc <= CRC_SEED;
      else if (en) crc <= crc_step(restart ? CRC_SEED : crc, word);
   end
endmodule

// File: rtl/lpp_reply_gen.sv
module lpp_reply_gen
   import lpp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] evt,
   input  logic              rp_ready,
   output logic              rp_valid,
   output logic [WORD_W-1:0] rp_data,
   output logic              rp_last,
   output logic              done
);
   logic              active;
   logic [1:0]        idx;
   logic [WORD_W-1:0] evt_q;
   logic [31:0]       crc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         idx    <= 2'd0;
         evt_q  <= '0;
         crc_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         idx    <= 2'd0;
         evt_q  <= evt;
         crc_q  <= crc_step(crc_step(CRC_SEED, REPLY_HDR), evt);
      end else if (active && rp_ready) begin
         if (idx == 2'd2) active <= 1'b0;
         else             idx    <= idx + 2'd1;
      end
   end

   always_comb begin
      rp_valid = active;
      rp_last  = (idx == 2'd2);
      case (idx)
         2'd0:    rp_data = REPLY_HDR;
         2'd1:    rp_data = evt_q;
         default: rp_data = crc_q;
      endcase
      done = active && rp_ready && rp_last;
   end
endmodule

// File: rtl/lpp_link_parser.sv
module lpp_link_parser
   import lpp_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit SAT_CNT = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              pl_valid,
   input  logic              pl_ready,
   output logic [WORD_W-1:0] pl_data,
   output logic              pl_last,
   output logic              rp_valid,
   input  logic              rp_ready,
   output logic [WORD_W-1:0] rp_data,
   output logic              rp_last,
   output logic              ping_ok,
   output logic              proto_err,
   output logic [CODE_W-1:0] err_code,
   output logic [CNT_W-1:0]  err_cnt
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("lpp_link_parser: CNT_W must lie in 1..32");
   end

   rx_state_e         state;
   pkt_kind_e         kind_q, dec_kind;
   logic [CODE_W-1:0] code_q, dec_code;
   logic [LEN_W-1:0]  remain, dec_len;
   logic [WORD_W-1:0] evt_q;
   logic [31:0]       crc_val;
   logic [CNT_W-1:0]  cnt_q;
   logic              acc, crc_en, crc_hit, crc_ok, good_end;
   logic              rg_start, rg_done, err_inc;

   lpp_hdr_decode u_dec (.hdr(in_data), .kind(dec_kind), .code(dec_code), .len(dec_len));

   lpp_crc_acc u_crc (
      .clk(clk), .rst(rst), .en(crc_en), .restart(state == S_HDR),
      .word(in_data), .crc(crc_val)
   );

   lpp_reply_gen u_rpl (
      .clk(clk), .rst(rst), .start(rg_start), .evt(evt_q), .rp_ready(rp_ready),
      .rp_valid(rp_valid), .rp_data(rp_data), .rp_last(rp_last), .done(rg_done)
   );

   always_comb begin
      in_ready = 1'b0;
      pl_valid = 1'b0;
      case (state)
         S_HDR, S_EVT, S_CRC: in_ready = 1'b1;
         S_PAY: begin
            if (kind_q == K_FWD) begin
               in_ready = pl_ready;
               pl_valid = in_valid;
            end else begin
               in_ready = 1'b1;
            end
         end
         default: in_ready = 1'b0;
      endcase
   end

   assign pl_data  = in_data;
   assign pl_last  = (remain == LEN_W'(1));
   assign acc      = in_valid && in_ready;
   assign crc_en   = acc && (state != S_CRC) && (state != S_RPL);
   assign crc_hit  = acc && (state == S_CRC);
   assign crc_ok   = (in_data == crc_val);
   assign good_end = crc_hit && crc_ok;
   assign rg_start = good_end && (kind_q == K_PING);
   assign err_inc  = good_end && (kind_q == K_ERR);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= S_HDR;
         kind_q    <= K_NOP;
         code_q    <= '0;
         remain    <= '0;
         evt_q     <= '0;
         ping_ok   <= 1'b0;
         proto_err <= 1'b0;
         err_code  <= '0;
      end else begin
         ping_ok <= 1'b0;
         case (state)
            S_HDR: if (acc) begin
               kind_q <= dec_kind;
               code_q <= dec_code;
               remain <= dec_len;
               state  <= S_EVT;
            end
            S_EVT: if (acc) begin
               evt_q <= in_data;
               state <= (remain == '0) ? S_CRC : S_PAY;
            end
            S_PAY: if (acc) begin
               remain <= remain - LEN_W'(1);
               if (remain == LEN_W'(1)) state <= S_CRC;
            end
            S_CRC: if (acc) begin
               state <= S_HDR;
               if (!crc_ok || kind_q == K_BAD) begin
                  proto_err <= 1'b1;
               end else begin
                  case (kind_q)
                     K_PING:  state    <= S_RPL;
                     K_PONG:  ping_ok  <= 1'b1;
                     K_ERR:   err_code <= code_q;
                     default: ;
                  endcase
               end
            end
            default: if (rg_done) state <= S_HDR;
         endcase
      end
   end

   if (SAT_CNT) begin : g_sat
      always_ff @(posedge clk) begin
         if (rst)                       cnt_q <= '0;
         else if (err_inc && !(&cnt_q)) cnt_q <= cnt_q + CNT_ONE;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst)          cnt_q <= '0;
         else if (err_inc) cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign err_cnt = cnt_q;
endmodule

// File: rtl/lpp_link_parser_chk.sv
module lpp_link_parser_chk #(
   parameter int CNT_W   = 8,
   parameter bit SAT_CNT = 1'b1
)(
   input logic             clk,
   input logic             rst,
   input logic             in_ready,
   input logic             pl_valid,
   input logic             pl_ready,
   input logic             rp_valid,
   input logic             rp_ready,
   input logic [31:0]      rp_data,
   input logic             ping_ok,
   input logic             proto_err,
   input logic [CNT_W-1:0] err_cnt
);
   AST_NO_INPUT_DURING_REPLY: assert property (@(posedge clk) disable iff (rst)
      rp_valid |-> !in_ready); // R5

   AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rp_valid && !rp_ready) |=> (rp_valid && $stable(rp_data))); // R5

   AST_PAYLOAD_STALL: assert property (@(posedge clk) disable iff (rst)
      (pl_valid && !pl_ready) |-> !in_ready); // R12

   AST_PING_OK_PULSE: assert property (@(posedge clk) disable iff (rst)
      ping_ok |=> !ping_ok); // R6

   AST_PROTO_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err); // R3

   AST_ERR_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + CNT_W'(1))); // R7

   if (SAT_CNT) begin : g_sat_chk
      AST_ERR_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
         (&$past(err_cnt)) |-> (&err_cnt)); // R11
   end
endmodule

bind lpp_link_parser lpp_link_parser_chk #(.CNT_W(CNT_W), .SAT_CNT(SAT_CNT)) u_chk (
   .clk(clk), .rst(rst), .in_ready(in_ready), .pl_valid(pl_valid), .pl_ready(pl_ready),
   .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_data(rp_data), .ping_ok(ping_ok),
   .proto_err(proto_err), .err_cnt(err_cnt)
);

// File: tb/tb_lpp_link_parser.sv
`timescale 1ns/1ps
module tb_lpp_link_parser;
   localparam int CNT_W = 8;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;

   typedef struct packed {
      logic [1:0]  ty;
      logic [13:0] fl;
      logic [3:0]  sz;
      logic [31:0] ev;
      logic        bad;
      logic        fwd;
      logic        rpl;
      logic        png;
      logic        err;
      logic        perr;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 14'h0000, 4'd3, 32'h0000_00A1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
      '{2'd1, 14'h0000, 4'd0, 32'h0000_00A2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
      '{2'd0, 14'h0001, 4'd0, 32'h0000_00A3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
      '{2'd0, 14'h0001, 4'd2, 32'h0000_00A4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
      '{2'd0, 14'h0002, 4'd1, 32'h0000_00A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
      '{2'd0, 14'h1ABC, 4'd1, 32'h0000_00A6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
      '{2'd1, 14'h1005, 4'd2, 32'h0000_00A7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
      '{2'd1, 14'h0001, 4'd1, 32'h0000_00A8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
      '{2'd1, 14'h0002, 4'd0, 32'h0000_00A9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
      '{2'd2, 14'h0000, 4'd2, 32'h0000_00AA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9
      '{2'd3, 14'h1001, 4'd0, 32'h0000_00AB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9
      '{2'd0, 14'h0005, 4'd1, 32'h0000_00AC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R13
      '{2'd0, 14'h0000, 4'd2, 32'h0000_00AD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R13
      '{2'd1, 14'h0000, 4'd2, 32'h0000_00AE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
      '{2'd0, 14'h0001, 4'd0, 32'h0000_00AF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R3
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [31:0]      in_data = '0;
   logic             pl_valid;
   logic             pl_ready = 1'b1;
   logic [31:0]      pl_data;
   logic             pl_last;
   logic             rp_valid;
   logic             rp_ready = 1'b1;
   logic [31:0]      rp_data;
   logic             rp_last;
   logic             ping_ok;
   logic             proto_err;
   logic [11:0]      err_code;
   logic [CNT_W-1:0] err_cnt;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] pl_cap [0:127];
   logic        pl_lst [0:127];
   logic [31:0] rp_cap [0:127];
   logic        rp_lst [0:127];
   int pl_n = 0;
   int rp_n = 0;
   int pong_n = 0;

   always #5 clk = ~clk;

   lpp_link_parser #(.CNT_W(CNT_W), .SAT_CNT(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
      .rp_valid(rp_valid), .rp_ready(rp_ready), .rp_data(rp_data), .rp_last(rp_last),
      .ping_ok(ping_ok), .proto_err(proto_err), .err_code(err_code), .err_cnt(err_cnt)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (pl_valid && pl_ready) begin
            if (pl_n < 128) begin pl_cap[pl_n] = pl_data; pl_lst[pl_n] = pl_last; end
            pl_n++;
         end
         if (rp_valid && rp_ready) begin
            if (rp_n < 128) begin rp_cap[rp_n] = rp_data; rp_lst[rp_n] = rp_last; end
            rp_n++;
         end
         if (ping_ok) pong_n++;
      end
   end

   function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] r;
      r = c ^ d;
      for (int k = 0; k < 32; k++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
      return r;
   endfunction

   function automatic string tag_of(input int v);
      case (v)
         0, 2, 3: return (v == 0) ? "R2" : "R4";
         1:       return "R10";
         4:       return "R6";
         5, 6:    return "R7";
         7, 8:    return "R8";
         9, 10:   return "R9";
         11, 12:  return "R13";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst = 1'b1; in_valid = 1'b0; pl_ready = 1'b1; rp_ready = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w);
      in_valid = 1'b1;
      in_data  = w;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [1:0] ty, input logic [13:0] fl, input int sz,
                           input logic [31:0] ev, input bit bad, input int drain);
      logic [31:0] c, w;
      w = {ty, fl, 16'(sz)};
      c = bcrc(32'hFFFF_FFFF, w);
      send_word(w);
      c = bcrc(c, ev);
      send_word(ev);
      for (int i = 0; i < sz; i++) begin
         w = {ev[15:0], 16'(i)};
         c = bcrc(c, w);
         send_word(w);
      end
      if (bad) c = c ^ 32'h1;
      send_word(c);
      repeat (drain) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int b_pl, b_rp, b_pg, exp_pl;
      logic [31:0] rc;

      // R1: reset state
      do_reset();
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
      chk(!pl_valid && !rp_valid && !ping_ok, "R1", "valids", {29'd0, pl_valid, rp_valid, ping_ok}, 32'd0);
      chk(proto_err == 1'b0, "R1", "proto_err", 32'(proto_err), 32'd0);
      chk(err_cnt == '0 && err_code == '0, "R1", "err_cnt/err_code", {err_code, 12'd0, err_cnt}, 32'd0);

      // table walk: one packet per vector, reset before each
      for (int v = 0; v < NV; v++) begin
         do_reset();
         b_pl = pl_n; b_rp = rp_n; b_pg = pong_n;
         send_pkt(VEC[v].ty, VEC[v].fl, int'(VEC[v].sz), VEC[v].ev, VEC[v].bad, 8);
         exp_pl = VEC[v].fwd ? int'(VEC[v].sz) : 0;
         chk(pl_n - b_pl == exp_pl, tag_of(v), "payload word count", 32'(pl_n - b_pl), 32'(exp_pl));
         if (pl_n - b_pl == exp_pl) begin
            for (int i = 0; i < exp_pl; i++) begin
               chk(pl_cap[b_pl+i] == {VEC[v].ev[15:0], 16'(i)}, tag_of(v), "payload word",
                   pl_cap[b_pl+i], {VEC[v].ev[15:0], 16'(i)});
               chk(pl_lst[b_pl+i] == (i == exp_pl - 1), tag_of(v), "pl_last",
                   32'(pl_lst[b_pl+i]), 32'(i == exp_pl - 1));
            end
         end
         chk(rp_n - b_rp == (VEC[v].rpl ? 3 : 0), tag_of(v), "reply word count",
             32'(rp_n - b_rp), VEC[v].rpl ? 32'd3 : 32'd0);
         if (VEC[v].rpl && rp_n - b_rp == 3) begin
            rc = bcrc(bcrc(32'hFFFF_FFFF, 32'h0002_0000), VEC[v].ev);
            chk(rp_cap[b_rp] == 32'h0002_0000, "R4", "reply header", rp_cap[b_rp], 32'h0002_0000);
            chk(rp_cap[b_rp+1] == VEC[v].ev, "R4", "reply event", rp_cap[b_rp+1], VEC[v].ev);
            chk(rp_cap[b_rp+2] == rc, "R4", "reply crc", rp_cap[b_rp+2], rc);
            chk(rp_lst[b_rp+2] && !rp_lst[b_rp] && !rp_lst[b_rp+1], "R4", "rp_last position",
                {29'd0, rp_lst[b_rp], rp_lst[b_rp+1], rp_lst[b_rp+2]}, 32'd1);
         end
         chk(pong_n - b_pg == (VEC[v].png ? 1 : 0), tag_of(v), "ping_ok pulses",
             32'(pong_n - b_pg), 32'(VEC[v].png));
         chk(err_cnt == CNT_W'(VEC[v].err), tag_of(v), "err_cnt", 32'(err_cnt), 32'(VEC[v].err));
         chk(err_code == (VEC[v].err ? VEC[v].fl[11:0] : 12'h000), tag_of(v), "err_code",
             32'(err_code), VEC[v].err ? 32'(VEC[v].fl[11:0]) : 32'd0);
         chk(proto_err == VEC[v].perr, tag_of(v), "proto_err", 32'(proto_err), 32'(VEC[v].perr));
      end

      // R12: payload sink stall blocks input
      do_reset();
      b_pl = pl_n;
      pl_ready = 1'b0;
      fork
         send_pkt(2'd1, 14'h0000, 2, 32'h0000_00B0, 1'b0, 6);
         begin
            do @(negedge clk); while (!pl_valid);
            for (int k = 0; k < 3; k++) begin
               chk(!in_ready, "R12", "in_ready during stall", 32'(in_ready), 32'd0);
               chk(pl_data == 32'h00B0_0000, "R12", "stalled payload word", pl_data, 32'h00B0_0000);
               @(negedge clk);
            end
            @(posedge clk); #1 pl_ready = 1'b1;
         end
      join
      chk(pl_n - b_pl == 2, "R12", "payload after stall", 32'(pl_n - b_pl), 32'd2);

      // R5: input blocked while reply is pending, reply word held
      do_reset();
      b_rp = rp_n;
      rp_ready = 1'b0;
      fork
         send_pkt(2'd0, 14'h0001, 0, 32'h0000_00C0, 1'b0, 12);
         begin
            do @(negedge clk); while (!rp_valid);
            for (int k = 0; k < 4; k++) begin
               chk(!in_ready, "R5", "in_ready during reply", 32'(in_ready), 32'd0);
               chk(rp_data == 32'h0002_0000, "R5", "held reply word", rp_data, 32'h0002_0000);
               @(negedge clk);
            end
            @(posedge clk); #1 rp_ready = 1'b1;
         end
      join
      chk(rp_n - b_rp == 3, "R5", "reply words after release", 32'(rp_n - b_rp), 32'd3);
      @(negedge clk);
      chk(in_ready, "R5", "in_ready after reply", 32'(in_ready), 32'd1);

      // R3: proto_err stays set across later good packets
      do_reset();
      send_pkt(2'd1, 14'h0000, 1, 32'h0000_00D0, 1'b1, 2);
      send_pkt(2'd0, 14'h0002, 0, 32'h0000_00D1, 1'b0, 2);
      chk(proto_err, "R3", "sticky proto_err", 32'(proto_err), 32'd1);

      // R11: error counter saturates
      do_reset();
      for (int k = 0; k < 260; k++)
         send_pkt(2'd0, 14'h1000 | 14'(k & 12'hFFF), 0, 32'(k), 1'b0, 0);
      repeat (2) @(negedge clk);
      chk(err_cnt == {CNT_W{1'b1}}, "R11", "saturated err_cnt", 32'(err_cnt), 32'(255));
      chk(err_code == 12'(259), "R7", "last err_code", 32'(err_code), 32'd259);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule